// File: doc/BRIEF.md
# Pattern-Toggled Bitstream Inverter

This block takes a serial bitstream, one bit per clock when the qualifier is high, and returns it either unchanged or complemented. It starts in pass mode, where each output bit copies its input bit. The raw input sequence 1,1,0 switches it to invert mode, where each output bit is the complement of its input bit. The raw input sequence 0,1,0 then switches it back to pass mode.

The output is a Mealy function: the current mode is XORed with the live input bit. The bit that completes a switching sequence still leaves in the old mode, and the new mode applies from the next qualified bit. A mode flag shows the current mode.

A six-state machine tracks the sequences. Its states are named for the mode and for the prefix matched so far:

- `PASS_NONE`: pass mode, no useful prefix.
- `PASS_ONE`: pass mode, last bit 1.
- `PASS_TWO`: pass mode, last two bits 1,1.
- `INV_NONE`: invert mode, no useful prefix.
- `INV_ZERO`: invert mode, last bit 0.
- `INV_ZO`: invert mode, last two bits 0,1.

Transitions happen only on a qualified bit:

- Pass mode, input 1: `PASS_NONE` goes to `PASS_ONE`, `PASS_ONE` goes to `PASS_TWO`, and `PASS_TWO` stays in `PASS_TWO`.
- Pass mode, input 0: `PASS_NONE` and `PASS_ONE` go to `PASS_NONE`. `PASS_TWO` goes to `INV_ZERO`. This is the arm transition, and the final 0 is kept as the start of the next sequence.
- Invert mode, input 0: `INV_NONE` and `INV_ZERO` go to `INV_ZERO`. `INV_ZO` goes to `PASS_NONE`. This is the disarm transition.
- Invert mode, input 1: `INV_NONE` stays in `INV_NONE`, `INV_ZERO` goes to `INV_ZO`, and `INV_ZO` goes to `INV_NONE`.

Top module: `bsi_stream_inverter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) selects pass mode (`inv_mode` = 0) and discards all earlier input history, so bits seen before reset cannot complete a sequence after it.
- R2: In pass mode, `bit_out` equals `bit_in` in the same cycle.
- R3: In pass mode, a qualified bit 0 whose two preceding qualified bits were 1,1 sets invert mode from the next cycle. That completing bit still leaves uninverted.
- R4: In invert mode, `bit_out` equals the complement of `bit_in` in the same cycle.
- R5: In invert mode, a qualified bit 0 whose two preceding qualified bits were 0,1 returns to pass mode from the next cycle. That completing bit still leaves inverted.
- R6: In pass mode, the sequence 0,1,0 has no effect on the mode.
- R7: In invert mode, the sequence 1,1,0 has no effect on the mode.
- R8: Sequences are matched on the raw input and may overlap, including across a mode change. For example, 1,1,0,1,0 arms on the third bit and disarms on the fifth, and 1,1,1,0 arms on the fourth bit.
- R9: While `bit_vld` is low, the mode and the history do not change, and the bit is not part of any sequence. `bit_out` is still `bit_in` XOR the current mode.
- R10: The input 0111010001110101, sent first bit first with every bit qualified after reset, gives the output 0111001001110011. It enters invert mode after bits 4 and 12 (counting from 0) and leaves it after bits 6 and 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial input bit |
| bit_vld | input | 1 | Qualifies `bit_in` for sequence tracking |
| bit_out | output | 1 | `bit_in` passed through or complemented, according to the current mode |
| inv_mode | output | 1 | Current mode: 1 = invert, 0 = pass |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. Both switching sequences and all six states are therefore reachable from short inputs. The vector table runs the 16-bit demonstration stream, which covers both mode changes twice and the 1,1,1,0 overlap. Directed runs then cover the cases the table cannot reach: reset in the middle of a sequence, sequences that the current mode ignores, the 1,1,0,1,0 overlap across a mode change, and gaps of unqualified bits inside a sequence.

// File: rtl/bsi_pkg.sv
package bsi_pkg;

    // Mode is carried in bit 2 of the state code: 1 = invert, 0 = pass.
    typedef enum logic [2:0] {
        PASS_NONE = 3'b000,
        PASS_ONE  = 3'b001,
        PASS_TWO  = 3'b010,
        INV_NONE  = 3'b100,
        INV_ZERO  = 3'b101,
        INV_ZO    = 3'b110
    } mode_state_e;

    localparam int unsigned MODE_BIT = 2;

endpackage

// File: rtl/bsi_mode_fsm.sv
module bsi_mode_fsm
    import bsi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic inv_mode
);

    mode_state_e state_q;
    mode_state_e state_n;

    // Next state: advances only on qualified bits.
    always_comb begin
        state_n = state_q;
        if (bit_vld) begin
            unique case (state_q)
                PASS_NONE: state_n = bit_in ? PASS_ONE : PASS_NONE;
                PASS_ONE:  state_n = bit_in ? PASS_TWO : PASS_NONE;
                // Arm: the closing 0 doubles as the first bit of 0,1,0.
                PASS_TWO:  state_n = bit_in ? PASS_TWO : INV_ZERO;
                INV_NONE:  state_n = bit_in ? INV_NONE : INV_ZERO;
                INV_ZERO:  state_n = bit_in ? INV_ZO   : INV_ZERO;
                // Disarm: the trailing 0 cannot start 1,1,0.
                INV_ZO:    state_n = bit_in ? INV_NONE : PASS_NONE;
                default:   state_n = PASS_NONE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PASS_NONE;
        end else begin
            state_q <= state_n;
        end
    end

    // Mode flag output.
    always_comb begin
        inv_mode = state_q[MODE_BIT];
    end

endmodule

// File: rtl/bsi_out_stage.sv
module bsi_out_stage (
    input  logic bit_in,
    input  logic inv_mode,
    output logic bit_out
);

    // Mealy output: the live input bit under the current mode.
    always_comb begin
        bit_out = bit_in ^ inv_mode;
    end

endmodule

// File: rtl/bsi_stream_inverter.sv
module bsi_stream_inverter (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic bit_out,
    output logic inv_mode
);

    logic mode_w;

    bsi_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .inv_mode (mode_w)
    );

    bsi_out_stage u_out (
        .bit_in   (bit_in),
        .inv_mode (mode_w),
        .bit_out  (bit_out)
    );

    assign inv_mode = mode_w;

endmodule

// File: rtl/bsi_stream_inverter_chk.sv
module bsi_stream_inverter_chk (
    input logic clk,
    input logic rst,
    input logic bit_in,
    input logic bit_vld,
    input logic inv_mode
);

    // Independent record of the last two qualified input bits.
    logic [1:0] hist_q;
    logic [1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 2'b00;
            cnt_q  <= 2'd0;
        end else if (bit_vld) begin
            hist_q <= {hist_q[0], bit_in};
            cnt_q  <= (cnt_q == 2'd2) ? cnt_q : cnt_q + 2'd1;
        end
    end

    logic arm_now;
    logic disarm_now;
    assign arm_now    = (cnt_q == 2'd2) && (hist_q == 2'b11) && !bit_in;
    assign disarm_now = (cnt_q == 2'd2) && (hist_q == 2'b01) && !bit_in;

    p_reset_pass_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !inv_mode);

    p_arm_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !inv_mode && arm_now) |=> inv_mode);

    p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && inv_mode && disarm_now) |=> !inv_mode);

    p_pass_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !inv_mode && !arm_now) |=> !inv_mode);

    p_inv_stays_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && inv_mode && !disarm_now) |=> inv_mode);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(inv_mode));

endmodule

bind bsi_stream_inverter bsi_stream_inverter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (bit_in),
    .bit_vld  (bit_vld),
    .inv_mode (inv_mode)
);

// File: tb/bsi_stream_inverter_tb.sv
module bsi_stream_inverter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    // {bit_vld, bit_in, expected bit_out, expected inv_mode}: demo stream (R10)
    localparam logic [3:0] VEC [16] = '{
        4'b1000, 4'b1110, 4'b1110, 4'b1110,
        4'b1000, 4'b1101, 4'b1011, 4'b1000,
        4'b1000, 4'b1110, 4'b1110, 4'b1110,
        4'b1000, 4'b1101, 4'b1011, 4'b1110
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_out;
    logic inv_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsi_stream_inverter dut_i (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .bit_out  (bit_out),
        .inv_mode (inv_mode)
    );

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    // Drive one bit at the falling edge, then check the Mealy output and the mode.
    task automatic step(input logic v, input logic b, input logic eo,
                        input logic em, input string tag);
        @(negedge clk);
        bit_vld = v;
        bit_in  = b;
        #1;
        check(bit_out, eo, {tag, " bit_out"});
        check(inv_mode, em, {tag, " inv_mode"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(inv_mode, 1'b0, "R1 mode after reset");

        // R10 demo stream (also R2, R3, R4, R5, R8 for 1,1,1,0)
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R10 bit %0d", i));
        end

        // R1: history before reset is discarded
        do_reset();
        step(1'b1, 1'b1, 1'b1, 1'b0, "R1 pre 1");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R1 pre 1b");
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1 post 0");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R1 still pass");

        // R6: 0,1,0 in pass mode
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 0");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6 1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 0 end");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6 R2 still pass");

        // R7: 1,1,0 in invert mode, then R5 disarm
        do_reset();
        step(1'b1, 1'b1, 1'b1, 1'b0, "R3 1");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R3 1b");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3 closing bit pass");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 R4 1");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 1b");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R7 0 end");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R7 still invert");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R5 1");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R5 closing bit inverted");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5 back to pass");

        // R8: 1,1,0,1,0 arms and disarms with a shared 0
        do_reset();
        step(1'b1, 1'b1, 1'b1, 1'b0, "R8 1");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R8 1b");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R8 arm");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R8 1c");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R8 disarm");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8 pass again");

        // R9: unqualified bits are skipped and the mode holds
        do_reset();
        step(1'b1, 1'b1, 1'b1, 1'b0, "R9 1");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R9 gap 0");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R9 1b");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R9 gap 1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R9 arm");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R9 gap inv 1");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R9 gap inv 0");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R9 0 stays");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R9 hold");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule